// File: doc/BRIEF.md
# Banked GPIO Controller with Edge Events

This block is a memory-mapped general-purpose I/O controller serving three banks of 32 pins. Software drives pin levels only through a pair of one-hot-style strobe registers, one that raises the selected outputs and one that lowers them, so no read-modify-write is ever needed to change a single pin. A direction register per bank decides which pins are driven, and the level register returns the synchronized pad state.

Each pin can watch for rising transitions, falling transitions or both. A detected transition latches a sticky bit in the bank's event register, which software clears by writing ones. A per-bank mask register decides which latched events reach the single combined interrupt line. A two-bit-per-pin function-select word per bank is kept as plain storage for the pad mux outside this block.

Register groups sit at fixed byte offsets, and within a group the banks are adjacent words (bank n at group offset + 4n): level 0x00, direction 0x0C, drive-high 0x18, drive-low 0x24, rise enable 0x30, fall enable 0x3C, event status 0x48, function select 0x54, event mask 0x9C.

Top module: `gpio_banked`

## Requirements
- R1: After reset every output drive bit, direction bit, enable, event, mask and function-select bit is 0, so pin_oe, pin_out and irq are all 0 and every mapped register reads 0.
- R2: A register is reached at byte address group offset + 4·bank (bank 0..2) with the offsets listed above; any other address, including one with addr[1:0] not 00, reads as 0 and a write to it changes no register.
- R3: Writing the drive-high word of a bank sets the output bit of every pin whose data bit is 1, takes effect on the clock edge of the write, and leaves pins with a 0 data bit unchanged; reading that address (or the drive-low address) returns the bank's output latch.
- R4: Writing the drive-low word of a bank clears the output bit of every pin whose data bit is 1 and leaves the others unchanged.
- R5: Direction bit 1 makes a pin an output (pin_oe bit 1), bit 0 an input; the written word reads back and appears on pin_oe one clock after the write.
- R6: The level register returns pin_in after a two-flop synchronizer: a change made between clock edges is readable after the second rising edge and not after the first.
- R7: An event bit latches on the third rising edge after a pin change when the pin rose with its rise enable set or fell with its fall enable set; with both enabled either direction latches; with neither it never latches.
- R8: Writing ones to the event-status word clears those bits and zero bits leave them alone; a transition detected in the same cycle as the clearing write wins and the bit stays set.
- R9: irq is 1 exactly when some event bit is 1 together with its mask bit (bit 1 = reported); a masked event still reads back as 1 in the status word.
- R10: Each function-select word stores 32 bits read back unchanged; pin p of the bank owns bits [2·(p mod 16)+1 : 2·(p mod 16)].
- R11: The event-mask word of each bank is stored as written and reads back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, committed on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 96 | Pad input levels, bank n on bits [32n+31:32n] |
| pin_out | output | 96 | Output latch per pin |
| pin_oe | output | 96 | Output enable per pin (direction) |
| irq | output | 1 | Combined masked event interrupt |

## Verification
The hardest case to reach from the ports is a clearing write to the event word landing in exactly the cycle that a new transition is detected on the same bit, because detection trails the pad change by the synchronizer and the edge comparator. The bench first latches the bit with one transition, then reverses the pin and issues the clearing write two falling edges later so that its commit edge is the detection edge, and expects the bit to remain set; a repeat of the write with no transition must then clear it.

// File: rtl/gpio_banked_pkg.sv
package gpio_banked_pkg;

  localparam int PINS_PER_BANK = 32;
  localparam int NUM_GRP       = 9;

  typedef enum logic [3:0] {
    GRP_LVL  = 4'd0,
    GRP_DIR  = 4'd1,
    GRP_SET  = 4'd2,
    GRP_CLR  = 4'd3,
    GRP_RISE = 4'd4,
    GRP_FALL = 4'd5,
    GRP_EVT  = 4'd6,
    GRP_FUNC = 4'd7,
    GRP_MASK = 4'd8
  } grp_e;

  // Word offset (byte offset / 4) of bank 0 of each register group.
  function automatic int grp_word_base(grp_e g);
    case (g)
      GRP_LVL:  return 'h00 / 4;
      GRP_DIR:  return 'h0C / 4;
      GRP_SET:  return 'h18 / 4;
      GRP_CLR:  return 'h24 / 4;
      GRP_RISE: return 'h30 / 4;
      GRP_FALL: return 'h3C / 4;
      GRP_EVT:  return 'h48 / 4;
      GRP_FUNC: return 'h54 / 4;
      default:  return 'h9C / 4;
    endcase
  endfunction

  // Transitions that the enables ask to record.
  function automatic logic [PINS_PER_BANK-1:0] edge_hits(
    input logic [PINS_PER_BANK-1:0] cur,
    input logic [PINS_PER_BANK-1:0] prev,
    input logic [PINS_PER_BANK-1:0] rise_en,
    input logic [PINS_PER_BANK-1:0] fall_en);
    return (cur & ~prev & rise_en) | (~cur & prev & fall_en);
  endfunction

  // Sticky status update: clear-by-one first, new hits override.
  function automatic logic [PINS_PER_BANK-1:0] sticky_next(
    input logic [PINS_PER_BANK-1:0] cur,
    input logic [PINS_PER_BANK-1:0] clr,
    input logic [PINS_PER_BANK-1:0] hits);
    return (cur & ~clr) | hits;
  endfunction

  // Drive latch update from the raise and lower strobes.
  function automatic logic [PINS_PER_BANK-1:0] drive_next(
    input logic [PINS_PER_BANK-1:0] cur,
    input logic [PINS_PER_BANK-1:0] raise,
    input logic [PINS_PER_BANK-1:0] lower);
    return (cur | raise) & ~lower;
  endfunction

  // Two-bit function field belonging to pin p of a bank.
  function automatic logic [1:0] func_field(
    input logic [PINS_PER_BANK-1:0] word, input int p);
    return word[2*(p % 16) +: 2];
  endfunction

endpackage

// File: rtl/gpio_banked_sync.sv
module gpio_banked_sync #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;
endmodule

// File: rtl/gpio_banked_decode.sv
module gpio_banked_decode
  import gpio_banked_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NBANK = 3,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output grp_e          grp,
  output logic [BW-1:0] bank
);
  always_comb begin
    hit  = 1'b0;
    grp  = GRP_LVL;
    bank = '0;
    if (addr[1:0] == 2'b00) begin
      for (int g = 0; g < NUM_GRP; g++) begin
        for (int b = 0; b < NBANK; b++) begin
          if (int'(addr[AW-1:2]) == grp_word_base(grp_e'(g[3:0])) + b) begin
            hit  = 1'b1;
            grp  = grp_e'(g[3:0]);
            bank = BW'(b);
          end
        end
      end
    end
  end
endmodule

// File: rtl/gpio_banked_bank.sv
module gpio_banked_bank
  import gpio_banked_pkg::*;
#(
  parameter int W = PINS_PER_BANK
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_i,
  input  logic         sel,
  input  logic         we,
  input  grp_e         grp,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] evt_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] edge_o
);
  logic [W-1:0] lvl_s, lvl_prev;
  logic [W-1:0] drv_q, dir_q, ren_q, fen_q, evt_q, mask_q, func_q;
  logic         wr_dir, wr_set, wr_clr, wr_ren, wr_fen, wr_evt, wr_func, wr_mask;

  gpio_banked_sync #(.W(W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pin_i),
    .q     (lvl_s)
  );

  assign wr_dir  = sel && we && (grp == GRP_DIR);
  assign wr_set  = sel && we && (grp == GRP_SET);
  assign wr_clr  = sel && we && (grp == GRP_CLR);
  assign wr_ren  = sel && we && (grp == GRP_RISE);
  assign wr_fen  = sel && we && (grp == GRP_FALL);
  assign wr_evt  = sel && we && (grp == GRP_EVT);
  assign wr_func = sel && we && (grp == GRP_FUNC);
  assign wr_mask = sel && we && (grp == GRP_MASK);

  assign edge_o = edge_hits(lvl_s, lvl_prev, ren_q, fen_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_prev <= '0;
      drv_q    <= '0;
      dir_q    <= '0;
      ren_q    <= '0;
      fen_q    <= '0;
      evt_q    <= '0;
      mask_q   <= '0;
      func_q   <= '0;
    end else begin
      lvl_prev <= lvl_s;
      drv_q    <= drive_next(drv_q, wr_set ? wdata : '0, wr_clr ? wdata : '0);
      evt_q    <= sticky_next(evt_q, wr_evt ? wdata : '0, edge_o);
      if (wr_dir)  dir_q  <= wdata;
      if (wr_ren)  ren_q  <= wdata;
      if (wr_fen)  fen_q  <= wdata;
      if (wr_mask) mask_q <= wdata;
      if (wr_func) func_q <= wdata;
    end
  end

  always_comb begin
    case (grp)
      GRP_LVL:  rdata = lvl_s;
      GRP_DIR:  rdata = dir_q;
      GRP_SET,
      GRP_CLR:  rdata = drv_q;
      GRP_RISE: rdata = ren_q;
      GRP_FALL: rdata = fen_q;
      GRP_EVT:  rdata = evt_q;
      GRP_FUNC: rdata = func_q;
      default:  rdata = mask_q;
    endcase
  end

  assign pin_o  = drv_q;
  assign pin_oe = dir_q;
  assign evt_o  = evt_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/gpio_banked.sv
module gpio_banked
  import gpio_banked_pkg::*;
#(
  parameter int NBANK = 3,
  parameter int AW    = 8,
  localparam int W    = PINS_PER_BANK,
  localparam int NPIN = NBANK * W,
  localparam int BW   = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [W-1:0]    bus_wdata,
  output logic [W-1:0]    bus_rdata,
  input  logic [NPIN-1:0] pin_in,
  output logic [NPIN-1:0] pin_out,
  output logic [NPIN-1:0] pin_oe,
  output logic            irq
);
  logic            dec_hit;
  grp_e            dec_grp;
  logic [BW-1:0]   dec_bank;
  logic [W-1:0]    bank_rd [NBANK];
  logic [NPIN-1:0] evt_all;
  logic [NPIN-1:0] mask_all;
  logic [NPIN-1:0] edge_all;

  gpio_banked_decode #(.AW(AW), .NBANK(NBANK)) u_dec (
    .addr (bus_addr),
    .hit  (dec_hit),
    .grp  (dec_grp),
    .bank (dec_bank)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic bank_sel;
    assign bank_sel = dec_hit && (int'(dec_bank) == b);

    gpio_banked_bank #(.W(W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .pin_i  (pin_in[b*W +: W]),
      .sel    (bank_sel),
      .we     (bus_we),
      .grp    (dec_grp),
      .wdata  (bus_wdata),
      .rdata  (bank_rd[b]),
      .pin_o  (pin_out[b*W +: W]),
      .pin_oe (pin_oe[b*W +: W]),
      .evt_o  (evt_all[b*W +: W]),
      .mask_o (mask_all[b*W +: W]),
      .edge_o (edge_all[b*W +: W])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NBANK; b++) begin
      if (dec_hit && int'(dec_bank) == b) bus_rdata = bank_rd[b];
    end
  end

  assign irq = |(evt_all & mask_all);
endmodule

// File: rtl/gpio_banked_chk.sv
module gpio_banked_chk #(
  parameter int NPIN = 96
) (
  input logic            clk,
  input logic            rst_n,
  input logic [7:0]      bus_addr,
  input logic            bus_we,
  input logic [31:0]     bus_wdata,
  input logic [NPIN-1:0] pin_out,
  input logic [NPIN-1:0] pin_oe,
  input logic            irq,
  input logic [NPIN-1:0] evt_all,
  input logic [NPIN-1:0] edge_all
);
  logic mask_wr;
  assign mask_wr = bus_we && (bus_addr == 8'h9C || bus_addr == 8'hA0 || bus_addr == 8'hA4);

  // R3: raise strobe on bank 0 drives the written pins high
  a_r3_raise_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h18) |=> ((pin_out[31:0] & $past(bus_wdata)) == $past(bus_wdata)));

  // R4: lower strobe on bank 0 drives the written pins low
  a_r4_lower_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h24) |=> ((pin_out[31:0] & $past(bus_wdata)) == '0));

  // R5: direction write appears on the enables
  a_r5_dir_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == 8'h0C) |=> (pin_oe[31:0] == $past(bus_wdata)));

  // R7: an event bit only appears after a detected transition
  a_r7_event_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_all & ~$past(evt_all) & ~$past(edge_all)) == '0));

  // R8: a detected transition always leaves its bit set, clear or not
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(edge_all) & ~evt_all) == '0));

  // R9: the interrupt rises only after a transition or a mask write
  a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(|edge_all) || $past(mask_wr)));
endmodule

bind gpio_banked gpio_banked_chk #(.NPIN(NPIN)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe),
  .irq       (irq),
  .evt_all   (evt_all),
  .edge_all  (edge_all)
);

// File: tb/gpio_banked_tb.sv
module gpio_banked_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [95:0] pin_in = '0;
  logic [95:0] pin_out;
  logic [95:0] pin_oe;
  logic        irq;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  gpio_banked u_dut (
    .clk (clk), .rst_n (rst_n), .bus_addr (bus_addr), .bus_we (bus_we),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .pin_in (pin_in),
    .pin_out (pin_out), .pin_oe (pin_oe), .irq (irq)
  );

  task automatic chk(input string req, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; the write commits at the next rising edge.
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, {64'd0, v}, {64'd0, exp});
  endtask

  task automatic t_reset;
    for (int a = 0; a < 'hA8; a += 4) rdchk("R1 reset register", 8'(a), 32'h0);
    chk("R1 reset oe", pin_oe, '0);
    chk("R1 reset out", pin_out, '0);
    chk("R1 reset irq", {95'd0, irq}, '0);
  endtask

  task automatic t_drive;
    wr(8'h18, 32'h0000_00F0);
    chk("R3 raise", {64'd0, pin_out[31:0]}, 96'hF0);
    wr(8'h18, 32'h0000_000F);
    chk("R3 zeros keep", {64'd0, pin_out[31:0]}, 96'hFF);
    wr(8'h24, 32'h0000_003C);
    chk("R4 lower", {64'd0, pin_out[31:0]}, 96'hC3);
    rdchk("R3 readback", 8'h18, 32'hC3);
    wr(8'h1C, 32'h8000_0001);
    chk("R2 bank1 raise", pin_out, {32'd0, 32'h8000_0001, 32'hC3});
  endtask

  task automatic t_dir;
    wr(8'h14, 32'hDEAD_BEEF);
    chk("R5 bank2 oe", pin_oe, {32'hDEAD_BEEF, 64'd0});
    rdchk("R5 readback", 8'h14, 32'hDEAD_BEEF);
    rdchk("R2 bank0 dir untouched", 8'h0C, 32'h0);
  endtask

  task automatic t_level;
    pin_in[40] = 1'b1;
    @(negedge clk);
    rdchk("R6 level after one edge", 8'h04, 32'h0);
    @(negedge clk);
    rdchk("R6 level after two edges", 8'h04, 32'h100);
    pin_in[40] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_edges;
    wr(8'h30, 32'h5);
    wr(8'h3C, 32'h6);
    pin_in[3:0] = 4'hF;
    repeat (2) @(negedge clk);
    rdchk("R7 not yet latched", 8'h48, 32'h0);
    @(negedge clk);
    rdchk("R7 rising latched", 8'h48, 32'h5);
    pin_in[3:0] = 4'h0;
    repeat (3) @(negedge clk);
    rdchk("R7 falling latched", 8'h48, 32'h7);
  endtask

  task automatic t_clear;
    wr(8'h48, 32'h1);
    rdchk("R8 clear one", 8'h48, 32'h6);
    wr(8'h48, 32'h0);
    rdchk("R8 zeros keep", 8'h48, 32'h6);
    wr(8'h48, 32'hFFFF_FFFF);
    rdchk("R8 clear all", 8'h48, 32'h0);
  endtask

  task automatic t_race;
    pin_in[2] = 1'b1;
    repeat (3) @(negedge clk);
    rdchk("R8 race setup", 8'h48, 32'h4);
    pin_in[2] = 1'b0;
    repeat (2) @(negedge clk);
    wr(8'h48, 32'h4);
    rdchk("R8 edge wins over clear", 8'h48, 32'h4);
    wr(8'h48, 32'h4);
    rdchk("R8 plain clear", 8'h48, 32'h0);
  endtask

  task automatic t_irq;
    pin_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    rdchk("R9 masked event visible", 8'h48, 32'h1);
    chk("R9 masked no irq", {95'd0, irq}, '0);
    wr(8'h9C, 32'h1);
    chk("R9 unmasked irq", {95'd0, irq}, 96'd1);
    rdchk("R11 mask readback", 8'h9C, 32'h1);
    wr(8'hA4, 32'hFFFF_FFFF);
    rdchk("R11 bank2 mask", 8'hA4, 32'hFFFF_FFFF);
    wr(8'h48, 32'h1);
    chk("R9 cleared irq", {95'd0, irq}, '0);
    pin_in[0] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic t_func;
    logic [31:0] v;
    wr(8'h58, 32'h0000_0024);
    rd(8'h58, v);
    chk("R10 readback", {64'd0, v}, 96'h24);
    chk("R10 pin17 field", {94'd0, 2'((v >> 2) & 32'h3)}, 96'd1);
    chk("R10 pin2 field", {94'd0, 2'((v >> 4) & 32'h3)}, 96'd2);
  endtask

  task automatic t_unmapped;
    wr(8'h60, 32'hFFFF_FFFF);
    rdchk("R2 unmapped read", 8'h60, 32'h0);
    wr(8'h0D, 32'hFFFF_FFFF);
    rdchk("R2 misaligned read", 8'h0D, 32'h0);
    rdchk("R2 dir unchanged", 8'h0C, 32'h0);
    chk("R2 oe unchanged", pin_oe, {32'hDEAD_BEEF, 64'd0});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_drive;
    t_dir;
    t_level;
    t_edges;
    t_clear;
    t_race;
    t_irq;
    t_func;
    t_unmapped;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule